// File: doc/BRIEF.md
# Decimal Up/Down Counter with End-of-Sequence Flag

This block is a four-bit synchronous counter that steps through the decimal digits 0 to 9. A direction input decides whether the value rises or falls on each active clock edge. When counting up, the value wraps from nine to zero. When counting down, it wraps from zero to nine. An active-low count enable gates the stepping. An active-low load input replaces the value with a supplied word on the next edge, and it does so whether or not counting is enabled. A synchronous reset clears the value.

A combinational flag, `maxMin`, marks the last value of the sequence for the direction now selected. That last value is nine when counting up and zero when counting down. The flag follows the direction input at once, without waiting for a clock. Logic downstream can therefore use it to see that the next step will wrap.

Top module: `decadeUpDown`

## Requirements
- R1: When `rst` is 1 at a rising edge of `clk`, `q` becomes 0000 after that edge. This happens regardless of `loadN`, `enN` and `upDn`.
- R2: When `rst` is 0 and `loadN` is 0 at an edge, `q` takes the value of `loadData` after that edge. This holds whatever the state of `enN` and `upDn`, so a load wins over counting.
- R3: When `rst` is 0, `loadN` is 1 and `enN` is 1 at an edge, `q` keeps its value.
- R4: When `rst` is 0, `loadN` is 1, `enN` is 0 and `upDn` is 1 (up), `q` rises by one at the edge if it is below 1001. If `q` is 1001, it becomes 0000.
- R5: When `rst` is 0, `loadN` is 1, `enN` is 0 and `upDn` is 0 (down), `q` falls by one at the edge if it is between 0001 and 1001. If `q` is 0000, it becomes 1001.
- R6: `maxMin` is 1 exactly when `upDn` is 1 and `q` is 1001, or when `upDn` is 0 and `q` is 0000. It is 0 for every other combination, and it responds to `upDn` within the same cycle, with no clock edge.
- R7: A change on `upDn` alters the direction from the very next enabled edge. This is the case even when the direction alternates every cycle.
- R8: A loaded value above 1001 (1010 to 1111) leaves the illegal range in one enabled step: counting up it goes to 0000 and counting down it goes to 1001. `maxMin` stays 0 while `q` holds such a value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enN | input | 1 | Count enable, active low |
| upDn | input | 1 | Direction: 1 counts up, 0 counts down |
| loadN | input | 1 | Parallel load, active low, synchronous |
| loadData | input | 4 | Value taken by a load |
| q | output | 4 | Present count |
| maxMin | output | 1 | End-of-sequence flag for the selected direction |

## Verification
The functions that can meet in one cycle are the parallel load and the count step. A second meeting is reset against load. The bench drives `loadN` low while `enN` is also low, with the count sitting at each wrap point and in both directions. A correct design shows the loaded word after that edge, never the stepped value. The cycle-accurate reference model, which applies reset, then load, then count in that order, decides every expected value. It also judges the flag in the same cycle each time the direction is flipped between edges.

// File: rtl/decadeUpDownPkg.sv
package decadeUpDownPkg;

  // Strobes from the control decode to the count register; at most one is set
  typedef struct packed {
    logic clear;
    logic load;
    logic stepUp;
    logic stepDown;
  } ctrlStrobes_t;

endpackage

// File: rtl/decadeUpDownCtrl.sv
module decadeUpDownCtrl
  import decadeUpDownPkg::*;
(
  input  logic         rst,
  input  logic         enN,
  input  logic         upDn,
  input  logic         loadN,
  output ctrlStrobes_t strobes
);

  logic loadReq;
  logic countReq;

  // Priority: reset, then load, then counting
  assign loadReq  = !loadN;
  assign countReq = !enN && loadN;

  always_comb begin
    strobes          = '0;
    strobes.clear    = rst;
    strobes.load     = !rst && loadReq;
    strobes.stepUp   = !rst && countReq && upDn;
    strobes.stepDown = !rst && countReq && !upDn;
  end

endmodule

// File: rtl/decadeUpDownPath.sv
module decadeUpDownPath
  import decadeUpDownPkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic             clk,
  input  ctrlStrobes_t     strobes,
  input  logic             upDn,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] q,
  output logic             maxMin
);

  localparam logic [WIDTH-1:0] TOP_VAL = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] ONE_VAL = WIDTH'(1);

  logic [WIDTH-1:0] countReg;
  logic [WIDTH-1:0] nextCount;
  logic             atTop;
  logic             atBottom;
  logic             outOfRange;

  assign atTop      = (countReg == TOP_VAL);
  assign atBottom   = (countReg == '0);
  assign outOfRange = (countReg > TOP_VAL);

  always_comb begin
    nextCount = countReg;
    if (strobes.clear) begin
      nextCount = '0;
    end else if (strobes.load) begin
      nextCount = loadData;
    end else if (strobes.stepUp) begin
      nextCount = (atTop || outOfRange) ? '0 : countReg + ONE_VAL;
    end else if (strobes.stepDown) begin
      nextCount = (atBottom || outOfRange) ? TOP_VAL : countReg - ONE_VAL;
    end
  end

  always_ff @(posedge clk) begin
    countReg <= nextCount;
  end

  assign q      = countReg;
  assign maxMin = upDn ? atTop : atBottom;

endmodule

// File: rtl/decadeUpDown.sv
module decadeUpDown
  import decadeUpDownPkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enN,
  input  logic             upDn,
  input  logic             loadN,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] q,
  output logic             maxMin
);

  ctrlStrobes_t strobes;

  decadeUpDownCtrl i_ctrl (
    .rst    (rst),
    .enN    (enN),
    .upDn   (upDn),
    .loadN  (loadN),
    .strobes(strobes)
  );

  decadeUpDownPath #(
    .WIDTH  (WIDTH),
    .MODULUS(MODULUS)
  ) i_path (
    .clk     (clk),
    .strobes (strobes),
    .upDn    (upDn),
    .loadData(loadData),
    .q       (q),
    .maxMin  (maxMin)
  );

endmodule

// File: rtl/decadeUpDownChk.sv
module decadeUpDownChk #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             enN,
  input logic             upDn,
  input logic             loadN,
  input logic [WIDTH-1:0] loadData,
  input logic [WIDTH-1:0] q,
  input logic             maxMin
);

  localparam logic [WIDTH-1:0] TOP_VAL = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] ONE_VAL = WIDTH'(1);

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> q == '0);

  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    !loadN |=> q == $past(loadData));

  // R3
  hold_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (loadN && enN) |=> $stable(q));

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (loadN && !enN && upDn && q < TOP_VAL) |=> q == $past(q) + ONE_VAL);

  // R4
  up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (loadN && !enN && upDn && q == TOP_VAL) |=> q == '0);

  // R5
  down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (loadN && !enN && !upDn && q == '0) |=> q == TOP_VAL);

  // R6
  flag_terminal_only_chk: assert property (@(posedge clk) disable iff (rst)
    maxMin |-> (q == '0 || q == TOP_VAL));

  // R8
  illegal_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (loadN && !enN && q > TOP_VAL) |=> (q == '0 || q == TOP_VAL));

endmodule

bind decadeUpDown decadeUpDownChk #(.WIDTH(WIDTH), .MODULUS(MODULUS)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .enN     (enN),
  .upDn    (upDn),
  .loadN   (loadN),
  .loadData(loadData),
  .q       (q),
  .maxMin  (maxMin)
);

// File: tb/test_decadeUpDown.sv
`timescale 1ns/1ps
module test_decadeUpDown;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enN = 1'b1;
  logic       upDn = 1'b1;
  logic       loadN = 1'b1;
  logic [3:0] loadData = '0;
  logic [3:0] q;
  logic       maxMin;

  int testsRun = 0;
  int testsFailed = 0;
  int model = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  decadeUpDown i_decadeUpDown (
    .clk(clk), .rst(rst), .enN(enN), .upDn(upDn),
    .loadN(loadN), .loadData(loadData), .q(q), .maxMin(maxMin)
  );

  function automatic bit expFlag(int v, bit up);
    return up ? (v == 9) : (v == 0);
  endfunction

  task automatic checkFlag(string tag);
    testsRun++;
    if (maxMin !== expFlag(model, upDn)) begin
      testsFailed++;
      $display("FAIL %s maxMin=%0b expected %0b (q model %0d dir %0b)",
               tag, maxMin, expFlag(model, upDn), model, upDn);
    end
  endtask

  // Apply inputs after a falling edge, check the flag, clock once, check q
  task automatic step(bit r, bit ld, bit en, bit up, int d, string tag);
    rst = r; loadN = ld; enN = en; upDn = up; loadData = 4'(d);
    #1;
    if (!r) checkFlag("R6");
    @(posedge clk);
    if (r) model = 0;
    else if (!ld) model = d;
    else if (!en) begin
      if (up) model = (model >= 9) ? 0 : model + 1;
      else    model = (model == 0 || model > 9) ? 9 : model - 1;
    end
    @(negedge clk);
    testsRun++;
    if (q !== 4'(model)) begin
      testsFailed++;
      $display("FAIL %s q=%0d expected %0d", tag, q, model);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1, 1, 1, 1, 0, "R1");
    step(1, 0, 0, 1, 5, "R1");            // reset beats load and count
    for (int i = 0; i < 13; i++) step(0, 1, 0, 1, 0, "R4");
    for (int i = 0; i < 13; i++) step(0, 1, 0, 0, 0, "R5");
    for (int i = 0; i < 4; i++)  step(0, 1, 1, i[0], 0, "R3");
    step(0, 0, 1, 1, 7, "R2");            // load while disabled
    step(0, 1, 1, 0, 0, "R3");
    step(0, 0, 0, 1, 9, "R2");            // load while counting up
    step(0, 0, 0, 1, 3, "R2");            // at top, load beats wrap
    step(0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 6, "R2");            // at bottom, load beats wrap
    for (int i = 0; i < 8; i++)  step(0, 1, 0, i[0], 0, "R7");
    step(0, 0, 1, 1, 9, "R2");
    for (int i = 0; i < 4; i++)  step(0, 1, 0, i[0], 0, "R7");
    step(0, 0, 1, 1, 12, "R8");
    step(0, 1, 1, 0, 0, "R8");            // flag low in illegal range
    step(0, 1, 0, 1, 0, "R8");
    step(0, 0, 1, 0, 14, "R8");
    step(0, 1, 0, 0, 0, "R8");
    step(0, 0, 1, 1, 15, "R8");
    step(0, 1, 0, 1, 0, "R8");
    step(0, 0, 0, 0, 2, "R2");
    step(1, 1, 0, 0, 0, "R1");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule